// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

This block is one general-purpose I/O port that sits on a 16-bit peripheral register bus. Each pin has a direction bit and an output data bit. Each pin's input is sampled through a synchronizer. Each pin can also raise an interrupt on a rising edge, a falling edge or both. Software sets or clears chosen output bits with a single write to a mask register, so no read-modify-write sequence is needed. Detected edges are held in a sticky pending register until software clears them. A single interrupt request goes to the system interrupt controller.

The pin count is a parameter: 15 pins for the wide port and 6 for the narrow one. A per-pin mode input hands a pin over to a peripheral. The port then drives the pin from that peripheral's output and enable signals, and its own GPIO registers keep their contents.

Top module: `gpio_edge_port`

## Requirements
- R1: After synchronous reset every register reads 0, `pin_oe` and `pin_out` are 0 and `irq` is low. Every pin is therefore an input with both edge interrupts disabled.
- R2: The direction register is at offset 0 and the output register at offset 1. Direction bit 1 makes the pin an output, and bit 0 makes it an input. With mode 0, `pin_oe` follows the direction register and `pin_out` follows the output register, one cycle after the register changes.
- R3: Offset 2 is read-only. It returns the pin levels after a two-flop synchronizer, whatever the direction of the pins.
- R4: A write to offset 6 sets to 1 every output bit whose write-data bit is 1, and leaves every other output bit unchanged.
- R5: A write to offset 7 clears to 0 every output bit whose write-data bit is 1, and leaves every other output bit unchanged.
- R6: The rising-enable register is at offset 4. With its bit set, a 0-to-1 change of that pin's synchronized level sets the pin's pending bit. A 1-to-0 change does not set it.
- R7: The falling-enable register is at offset 3. With its bit set, a 1-to-0 change of that pin's synchronized level sets the pin's pending bit.
- R8: An edge on a pin whose enable for that edge direction is 0 leaves the pending register unchanged.
- R9: The pending register is at offset 5. Writing 1 to a bit clears it. Writing 0 to a bit leaves it unchanged, and no other event clears a pending bit.
- R10: When an enabled edge and a write-1-to-clear hit the same pending bit in the same cycle, the bit stays set.
- R11: `irq` is high exactly when at least one pending bit is set.
- R12: When a pin's `periph_mode` bit is 1, `pin_out` and `pin_oe` for that pin follow `periph_out` and `periph_oe` one cycle later. The GPIO direction and output registers keep their values.
- R13: Read data appears on `bus_rdata` one cycle after the read is presented. Offsets 6, 7 and 8 through 15 read as 0, and bits above the pin count read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pin_in | input | PIN_COUNT | Pin levels from the pads |
| pin_out | output | PIN_COUNT | Level driven to the pads |
| pin_oe | output | PIN_COUNT | Pad output enable |
| periph_mode | input | PIN_COUNT | 1 = pin owned by the peripheral |
| periph_out | input | PIN_COUNT | Peripheral output level |
| periph_oe | input | PIN_COUNT | Peripheral output enable |
| irq | output | 1 | Combined port interrupt request |

## Verification
The hardest situation to reach from the ports is an enabled edge that reaches the pending logic in the same cycle as a write-1-to-clear to that bit. The edge arrives only after two synchronizer flops and one comparison stage. The bench changes the pin on a falling clock edge and counts two rising edges. It then issues the clear write so that the write is captured on exactly the edge where the new pending bit is set. It then checks that the bit survived, and that a later clear with no edge does remove it.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int REG_ADDR_W = 4;
  localparam int BUS_DATA_W = 16;

  typedef enum logic [REG_ADDR_W-1:0] {
    OFS_DIR  = 4'd0,
    OFS_OUT  = 4'd1,
    OFS_IN   = 4'd2,
    OFS_FALL = 4'd3,
    OFS_RISE = 4'd4,
    OFS_PEND = 4'd5,
    OFS_SET  = 4'd6,
    OFS_CLR  = 4'd7
  } gpio_ofs_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 15,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  // Synchronizer chain; stage 0 takes the raw pad level.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= '0;
        else     chain_q[s] <= pin_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= '0;
        else     chain_q[s] <= chain_q[s-1];
      end
    end
  end

  // Previous synchronized sample, for edge comparison.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~prev_q;
  assign fall  = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/gpio_out_ctrl.sv
module gpio_out_ctrl #(
  parameter int WIDTH = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_dir,
  input  logic             wr_out,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] mode,
  input  logic [WIDTH-1:0] periph_out,
  input  logic [WIDTH-1:0] periph_oe,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] odata_q,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);

  always_ff @(posedge clk) begin
    if (rst)         dir_q <= '0;
    else if (wr_dir) dir_q <= wdata;
  end

  // Whole-word load, or atomic set / clear of the masked bits.
  always_ff @(posedge clk) begin
    if (rst)         odata_q <= '0;
    else if (wr_out) odata_q <= wdata;
    else if (wr_set) odata_q <= odata_q | wdata;
    else if (wr_clr) odata_q <= odata_q & ~wdata;
  end

  // Registered pad drive, selecting the owner per pin.
  for (genvar i = 0; i < WIDTH; i++) begin : g_pad
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[i] <= 1'b0;
        pin_oe[i]  <= 1'b0;
      end else if (mode[i]) begin
        pin_out[i] <= periph_out[i];
        pin_oe[i]  <= periph_oe[i];
      end else begin
        pin_out[i] <= odata_q[i];
        pin_oe[i]  <= dir_q[i];
      end
    end
  end

endmodule

// File: rtl/gpio_irq_pend.sv
module gpio_irq_pend #(
  parameter int WIDTH = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_fall_en,
  input  logic             wr_rise_en,
  input  logic             wr_pend,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] rise,
  input  logic [WIDTH-1:0] fall,
  output logic [WIDTH-1:0] fall_en_q,
  output logic [WIDTH-1:0] rise_en_q,
  output logic [WIDTH-1:0] pend_q,
  output logic             irq
);

  logic [WIDTH-1:0] pend_d;

  always_ff @(posedge clk) begin
    if (rst)             fall_en_q <= '0;
    else if (wr_fall_en) fall_en_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)             rise_en_q <= '0;
    else if (wr_rise_en) rise_en_q <= wdata;
  end

  // Per-pin sticky bit: an enabled edge beats a write-1-to-clear.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic hit;
    logic wipe;
    assign hit  = (rise[i] & rise_en_q[i]) | (fall[i] & fall_en_q[i]);
    assign wipe = wr_pend & wdata[i];
    always_comb begin
      if (hit)       pend_d[i] = 1'b1;
      else if (wipe) pend_d[i] = 1'b0;
      else           pend_d[i] = pend_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq    <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq    <= |pend_d;
    end
  end

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT   = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [BUS_DATA_W-1:0] bus_wdata,
  output logic [BUS_DATA_W-1:0] bus_rdata,
  input  logic [PIN_COUNT-1:0]  pin_in,
  output logic [PIN_COUNT-1:0]  pin_out,
  output logic [PIN_COUNT-1:0]  pin_oe,
  input  logic [PIN_COUNT-1:0]  periph_mode,
  input  logic [PIN_COUNT-1:0]  periph_out,
  input  logic [PIN_COUNT-1:0]  periph_oe,
  output logic                  irq
);

  localparam int PAD_W = BUS_DATA_W - PIN_COUNT;

  logic                 do_wr;
  logic                 do_rd;
  logic [PIN_COUNT-1:0] wdata_pins;
  logic [PIN_COUNT-1:0] level_w, rise_w, fall_w;
  logic [PIN_COUNT-1:0] dir_w, odata_w, fall_en_w, rise_en_w, pend_w;
  logic [PIN_COUNT-1:0] rd_pins;

  assign do_wr      = bus_sel & bus_wr;
  assign do_rd      = bus_sel & ~bus_wr;
  assign wdata_pins = bus_wdata[PIN_COUNT-1:0];

  if (PAD_W > 0) begin : g_pad_unused
    logic unused_hi_bits;
    assign unused_hi_bits = ^bus_wdata[BUS_DATA_W-1:PIN_COUNT];
  end

  gpio_in_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_in (pin_in),
    .level  (level_w),
    .rise   (rise_w),
    .fall   (fall_w)
  );

  gpio_out_ctrl #(.WIDTH(PIN_COUNT)) u_out (
    .clk        (clk),
    .rst        (rst),
    .wr_dir     (do_wr && bus_addr == OFS_DIR),
    .wr_out     (do_wr && bus_addr == OFS_OUT),
    .wr_set     (do_wr && bus_addr == OFS_SET),
    .wr_clr     (do_wr && bus_addr == OFS_CLR),
    .wdata      (wdata_pins),
    .mode       (periph_mode),
    .periph_out (periph_out),
    .periph_oe  (periph_oe),
    .dir_q      (dir_w),
    .odata_q    (odata_w),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe)
  );

  gpio_irq_pend #(.WIDTH(PIN_COUNT)) u_pend (
    .clk        (clk),
    .rst        (rst),
    .wr_fall_en (do_wr && bus_addr == OFS_FALL),
    .wr_rise_en (do_wr && bus_addr == OFS_RISE),
    .wr_pend    (do_wr && bus_addr == OFS_PEND),
    .wdata      (wdata_pins),
    .rise       (rise_w),
    .fall       (fall_w),
    .fall_en_q  (fall_en_w),
    .rise_en_q  (rise_en_w),
    .pend_q     (pend_w),
    .irq        (irq)
  );

  always_comb begin
    case (bus_addr)
      OFS_DIR:  rd_pins = dir_w;
      OFS_OUT:  rd_pins = odata_w;
      OFS_IN:   rd_pins = level_w;
      OFS_FALL: rd_pins = fall_en_w;
      OFS_RISE: rd_pins = rise_en_w;
      OFS_PEND: rd_pins = pend_w;
      default:  rd_pins = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (do_rd) bus_rdata <= BUS_DATA_W'(rd_pins);
    else            bus_rdata <= '0;
  end

endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 15
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_sel,
  input logic                  bus_wr,
  input logic [REG_ADDR_W-1:0] bus_addr,
  input logic [BUS_DATA_W-1:0] bus_wdata,
  input logic                  irq,
  input logic [PIN_COUNT-1:0]  odata_w,
  input logic [PIN_COUNT-1:0]  pend_w,
  input logic [PIN_COUNT-1:0]  rise_en_w,
  input logic [PIN_COUNT-1:0]  fall_en_w
);

  logic wr_set, wr_clr, wr_pend;
  assign wr_set  = bus_sel && bus_wr && bus_addr == OFS_SET;
  assign wr_clr  = bus_sel && bus_wr && bus_addr == OFS_CLR;
  assign wr_pend = bus_sel && bus_wr && bus_addr == OFS_PEND;

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irq && pend_w == '0 && odata_w == '0));

  // R4
  p_set_mask_r4: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> odata_w == ($past(odata_w) | $past(bus_wdata[PIN_COUNT-1:0])));

  // R5
  p_clr_mask_r5: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> odata_w == ($past(odata_w) & ~$past(bus_wdata[PIN_COUNT-1:0])));

  // R8
  p_pend_enabled_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_w & ~$past(pend_w)) & ~($past(rise_en_w) | $past(fall_en_w))) == '0);

  // R9
  p_pend_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_pend |=> (pend_w & $past(pend_w)) == $past(pend_w));

  // R11
  p_irq_any_r11: assert property (@(posedge clk) disable iff (rst)
    irq == (|pend_w));

endmodule

bind gpio_edge_port gpio_edge_port_chk #(.PIN_COUNT(PIN_COUNT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .odata_w   (odata_w),
  .pend_w    (pend_w),
  .rise_en_w (rise_en_w),
  .fall_en_w (fall_en_w)
);

// File: tb/test_gpio_edge_port.sv
`timescale 1ns/1ps
module test_gpio_edge_port;

  localparam int PC = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic [PC-1:0] pin_in = '0;
  logic [PC-1:0] pin_out, pin_oe;
  logic [PC-1:0] periph_mode = '0;
  logic [PC-1:0] periph_out = '0;
  logic [PC-1:0] periph_oe = '0;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_edge_port #(.PIN_COUNT(PC)) i_gpio_edge_port (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .periph_mode(periph_mode), .periph_out(periph_out),
    .periph_oe(periph_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int a = 0; a < 6; a++) begin
      bus_read(4'(a), d);
      chk("R1 register after reset", d, 16'h0);
    end
    chk("R1 pin_oe after reset", pin_oe, '0);
    chk("R1 pin_out after reset", pin_out, '0);
    chk("R1 irq after reset", irq, 0);
  endtask

  task automatic t_direction();
    logic [15:0] d;
    bus_write(4'd0, 16'h00F0);
    bus_write(4'd1, 16'h0050);
    @(posedge clk); @(negedge clk);
    chk("R2 pin_oe follows direction", pin_oe, 15'h00F0);
    chk("R2 pin_out follows output reg", pin_out, 15'h0050);
    bus_read(4'd0, d);
    chk("R2 direction readback", d, 16'h00F0);
  endtask

  task automatic t_set_clear();
    logic [15:0] d;
    bus_write(4'd1, 16'h1234);
    bus_write(4'd6, 16'h00F0);
    bus_read(4'd1, d);
    chk("R4 set mask", d, 16'h12F4);
    bus_write(4'd7, 16'h1204);
    bus_read(4'd1, d);
    chk("R5 clear mask", d, 16'h00F0);
    chk("R5 pin_out after clear", pin_out, 15'h00F0);
  endtask

  task automatic t_input();
    logic [15:0] d;
    pin_in = 15'h5A5A;
    settle(3);
    bus_read(4'd2, d);
    chk("R3 input incl output pins", d, 16'h5A5A);
    pin_in = 15'h25A5;
    settle(3);
    bus_read(4'd2, d);
    chk("R3 input second pattern", d, 16'h25A5);
    pin_in = '0;
    settle(4);
    bus_write(4'd5, 16'h7FFF);
  endtask

  task automatic t_rise();
    logic [15:0] d;
    bus_write(4'd4, 16'h0003);
    bus_write(4'd3, 16'h0000);
    pin_in[0] = 1'b1;
    settle(4);
    bus_read(4'd5, d);
    chk("R6 rising edge pends", d, 16'h0001);
    chk("R11 irq with pending", irq, 1);
    pin_in[0] = 1'b0;
    settle(4);
    bus_read(4'd5, d);
    chk("R6 falling edge ignored by rise enable", d, 16'h0001);
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    bus_write(4'd5, 16'h0002);
    bus_read(4'd5, d);
    chk("R9 writing 0 keeps bit", d, 16'h0001);
    bus_write(4'd5, 16'h0001);
    bus_read(4'd5, d);
    chk("R9 write 1 clears", d, 16'h0000);
    chk("R11 irq low when none pending", irq, 0);
  endtask

  task automatic t_fall();
    logic [15:0] d;
    bus_write(4'd4, 16'h0000);
    bus_write(4'd3, 16'h0004);
    pin_in[2] = 1'b1;
    settle(4);
    bus_read(4'd5, d);
    chk("R8 rising edge with only fall enabled", d, 16'h0000);
    pin_in[2] = 1'b0;
    settle(4);
    bus_read(4'd5, d);
    chk("R7 falling edge pends", d, 16'h0004);
  endtask

  task automatic t_disabled();
    logic [15:0] d;
    pin_in[5] = 1'b1; settle(4);
    pin_in[5] = 1'b0; settle(4);
    bus_read(4'd5, d);
    chk("R8 disabled pin edges ignored", d, 16'h0004);
  endtask

  task automatic t_or();
    logic [15:0] d;
    bus_write(4'd4, 16'h0100);
    pin_in[8] = 1'b1;
    settle(4);
    bus_read(4'd5, d);
    chk("R11 two bits pending", d, 16'h0104);
    bus_write(4'd5, 16'h0004);
    chk("R11 irq with one left", irq, 1);
    bus_write(4'd5, 16'h0100);
    chk("R11 irq after last clear", irq, 0);
    pin_in[8] = 1'b0;
    settle(4);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    bus_write(4'd3, 16'h0000);
    bus_write(4'd4, 16'h0400);
    pin_in[10] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_write(4'd5, 16'h0400);
    bus_read(4'd5, d);
    chk("R10 edge beats same-cycle clear", d, 16'h0400);
    chk("R10 irq stays high", irq, 1);
    bus_write(4'd5, 16'h0400);
    bus_read(4'd5, d);
    chk("R10 later clear works", d, 16'h0000);
  endtask

  task automatic t_periph();
    logic [15:0] d;
    periph_mode = 15'h000F; periph_out = 15'h0005; periph_oe = 15'h000A;
    @(posedge clk); @(negedge clk);
    chk("R12 pin_oe peripheral mix", pin_oe, 15'h00FA);
    chk("R12 pin_out peripheral mix", pin_out, 15'h00F5);
    bus_read(4'd0, d);
    chk("R12 direction kept", d, 16'h00F0);
    periph_mode = '0;
    @(posedge clk); @(negedge clk);
    chk("R12 back to GPIO drive", pin_out, 15'h00F0);
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    bus_read(4'd6, d); chk("R13 set-mask reads 0", d, 16'h0);
    bus_read(4'd7, d); chk("R13 clear-mask reads 0", d, 16'h0);
    bus_read(4'd9, d); chk("R13 offset 9 reads 0", d, 16'h0);
    bus_read(4'd15, d); chk("R13 offset 15 reads 0", d, 16'h0);
    bus_write(4'd0, 16'hFFFF);
    bus_read(4'd0, d); chk("R13 bits above pins read 0", d, 16'h7FFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_direction();
    t_set_clear();
    t_input();
    t_rise();
    t_w1c();
    t_fall();
    t_disabled();
    t_or();
    t_set_wins();
    t_periph();
    t_unmapped();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule